// File: doc/BRIEF.md
# Programmable Raster Sync Generator

The block makes the horizontal sync, horizontal blank, vertical sync, vertical blank and composite sync levels for a raster display. It keeps its own beam position: a horizontal counter that counts up to a programmed line length, and a vertical counter that steps once per line up to a programmed frame length. Each output is a set/clear flag. It is set when the beam reaches its programmed start value and cleared when the beam reaches its programmed stop value.

Software loads eleven timing registers and one mode register through a single-cycle write port. The programmed comparisons stay off after reset. Writing a changed value to any horizontal register turns on the horizontal comparisons, and writing a changed value to any vertical register turns on the vertical ones. A nonzero write to the mode register turns on both at once. The vertical sync edges are taken at one of two points on the line: the sync-start point on a short field, or the line-centre point on a long field, which gives the half-line offset needed for interlace. In dual-counter mode, an external horizontal count takes the place of the internal one for all horizontal comparisons.

Top module: `rsg_sync_gen`

## Requirements
- R1: During and right after reset: all five sync outputs are 0, both position outputs are 0, both comparison enables are off, and the timing registers hold their parameter defaults (line length 227, frame length 312, sync start 18, sync stop 35, blank start 9, blank stop 44, centre 132, vertical sync 2 to 5, vertical blank 0 to 20).
- R2: `hpos` goes to 0 on the clock after it equals the line-length register, and otherwise increments. `vpos` changes only on that wrap: it goes to 0 if it equals the frame-length register, and otherwise increments.
- R3: With horizontal comparisons enabled, `hsync` becomes 1 on the clock after the compared position equals sync-start, and becomes 0 on the clock after it equals sync-stop. When both match, stop wins. Otherwise `hsync` holds.
- R4: The blank start and stop registers store 11 bits. Only their low 8 bits are compared (zero-extended) against the position to set and clear `hblank`, with stop winning.
- R5: On a short field (`long_frame`=0), with vertical comparisons enabled, `vsync` changes only on the clock after the compared position equals sync-start. It is set if `vpos` equals vsync-start and cleared if `vpos` equals vsync-stop, with stop winning.
- R6: On a long field (`long_frame`=1), the same vertical sync evaluation happens when the compared position equals the centre register instead of sync-start.
- R7: With vertical comparisons enabled, `vblank` becomes 1 on the clock after `vpos` equals vblank-start and becomes 0 on the clock after `vpos` equals vblank-stop, with stop winning.
- R8: When `dual_mode`=1, every horizontal comparison (both syncs, blank, centre) uses `hpos_alt` in place of the internal horizontal counter. The counters themselves are not affected.
- R9: While horizontal comparisons are off, `hsync` and `hblank` hold their values. While vertical comparisons are off, `vsync` and `vblank` hold. Once set, an enable stays on until reset.
- R10: Register map (`wr_addr`): 0 line length, 1 hsync start, 2 hsync stop, 3 hblank start, 4 hblank stop, 5 centre, 6 frame length, 7 vsync start, 8 vsync stop, 9 vblank start, 10 vblank stop, 11 mode. A mode write with any of `wr_data[7:0]` nonzero turns on both enables. A mode write with those bits all zero has no effect.
- R11: A write whose masked value equals the stored value changes nothing and does not turn on an enable.
- R12: Horizontal values (addresses 0,1,2,5) are masked to 9 bits, blank values (3,4) to 11 bits, and vertical values (6 to 10) to 11 bits before they are stored and compared.
- R13: `csync` is the OR of the next `hsync` and `vsync` values, registered on the same edge, so it always equals `hsync | vsync`.
- R14: Every output is registered. A register write at one edge is first used by the comparison made in the cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register select (map in R10) |
| wr_data | input | 16 | Write value |
| dual_mode | input | 1 | Compare horizontal registers against `hpos_alt` |
| hpos_alt | input | 9 | Secondary horizontal count |
| long_frame | input | 1 | Long (interlace) field flag |
| hpos | output | 9 | Internal horizontal counter |
| vpos | output | 11 | Internal vertical counter |
| hsync | output | 1 | Programmed horizontal sync |
| hblank | output | 1 | Programmed horizontal blank |
| vsync | output | 1 | Programmed vertical sync |
| vblank | output | 1 | Programmed vertical blank |
| csync | output | 1 | Composite sync |

## Verification
The checker holds on every cycle the properties that relate state directly: counter stepping and wrapping, the sticky enables, every output holding while its enable is off, every `hsync` rise coming from a sync-start match, and `csync` tracking both syncs. Only the bench scenarios can show the register-side behaviour. This covers masking of noisy high data bits, ignoring unchanged writes, the mode register's all-zero case, the low-byte blank compare against 11-bit values, switching the vertical point between short and long fields, and the external count in dual mode. The bench covers these with a cycle-level reference model driven by random writes, plus directed sequences.

// File: rtl/rsg_pkg.sv
// Shared definitions for the raster sync generator.
// Assumes a 4-bit register select; the mode-enable field is the low byte.
package rsg_pkg;
    typedef enum logic [3:0] {
        RSG_HTOT  = 4'd0,
        RSG_HSON  = 4'd1,
        RSG_HSOFF = 4'd2,
        RSG_HBON  = 4'd3,
        RSG_HBOFF = 4'd4,
        RSG_HMID  = 4'd5,
        RSG_VTOT  = 4'd6,
        RSG_VSON  = 4'd7,
        RSG_VSOFF = 4'd8,
        RSG_VBON  = 4'd9,
        RSG_VBOFF = 4'd10,
        RSG_MODE  = 4'd11
    } rsg_addr_e;

    localparam int RSG_MODE_BITS = 8;
endpackage

// File: rtl/rsg_regfile.sv
// Timing register file with write masking, the change-only update rule and
// the two sticky comparison enables. Assumes DW >= BW and DW >= VW.
module rsg_regfile
    import rsg_pkg::*;
#(
    parameter int HW        = 9,
    parameter int VW        = 11,
    parameter int BW        = 11,
    parameter int AW        = 4,
    parameter int DW        = 16,
    parameter int HTOT_RST  = 227,
    parameter int HSON_RST  = 18,
    parameter int HSOFF_RST = 35,
    parameter int HBON_RST  = 9,
    parameter int HBOFF_RST = 44,
    parameter int HMID_RST  = 132,
    parameter int VTOT_RST  = 312,
    parameter int VSON_RST  = 2,
    parameter int VSOFF_RST = 5,
    parameter int VBON_RST  = 0,
    parameter int VBOFF_RST = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [HW-1:0] htotal,
    output logic [HW-1:0] hs_on,
    output logic [HW-1:0] hs_off,
    output logic [BW-1:0] hb_on,
    output logic [BW-1:0] hb_off,
    output logic [HW-1:0] hmid,
    output logic [VW-1:0] vtotal,
    output logic [VW-1:0] vs_on,
    output logic [VW-1:0] vs_off,
    output logic [VW-1:0] vb_on,
    output logic [VW-1:0] vb_off,
    output logic          h_en,
    output logic          v_en
);
    localparam int TOPW = (BW > VW) ? BW : VW;

    logic [HW-1:0] h_val;
    logic [BW-1:0] b_val;
    logic [VW-1:0] v_val;
    logic          mode_hit;
    logic          unused_wr_hi;

    // Masked views of the write value per register class.
    always_comb begin
        h_val    = wr_data[HW-1:0];
        b_val    = wr_data[BW-1:0];
        v_val    = wr_data[VW-1:0];
        mode_hit = |wr_data[RSG_MODE_BITS-1:0];
    end

    assign unused_wr_hi = ^wr_data[DW-1:TOPW];

    // Store changed values and raise the matching enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            htotal <= HW'(HTOT_RST);
            hs_on  <= HW'(HSON_RST);
            hs_off <= HW'(HSOFF_RST);
            hb_on  <= BW'(HBON_RST);
            hb_off <= BW'(HBOFF_RST);
            hmid   <= HW'(HMID_RST);
            vtotal <= VW'(VTOT_RST);
            vs_on  <= VW'(VSON_RST);
            vs_off <= VW'(VSOFF_RST);
            vb_on  <= VW'(VBON_RST);
            vb_off <= VW'(VBOFF_RST);
            h_en   <= 1'b0;
            v_en   <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                AW'(RSG_HTOT):  if (h_val != htotal) begin htotal <= h_val; h_en <= 1'b1; end
                AW'(RSG_HSON):  if (h_val != hs_on)  begin hs_on  <= h_val; h_en <= 1'b1; end
                AW'(RSG_HSOFF): if (h_val != hs_off) begin hs_off <= h_val; h_en <= 1'b1; end
                AW'(RSG_HBON):  if (b_val != hb_on)  begin hb_on  <= b_val; h_en <= 1'b1; end
                AW'(RSG_HBOFF): if (b_val != hb_off) begin hb_off <= b_val; h_en <= 1'b1; end
                AW'(RSG_HMID):  if (h_val != hmid)   begin hmid   <= h_val; h_en <= 1'b1; end
                AW'(RSG_VTOT):  if (v_val != vtotal) begin vtotal <= v_val; v_en <= 1'b1; end
                AW'(RSG_VSON):  if (v_val != vs_on)  begin vs_on  <= v_val; v_en <= 1'b1; end
                AW'(RSG_VSOFF): if (v_val != vs_off) begin vs_off <= v_val; v_en <= 1'b1; end
                AW'(RSG_VBON):  if (v_val != vb_on)  begin vb_on  <= v_val; v_en <= 1'b1; end
                AW'(RSG_VBOFF): if (v_val != vb_off) begin vb_off <= v_val; v_en <= 1'b1; end
                AW'(RSG_MODE):  if (mode_hit) begin h_en <= 1'b1; v_en <= 1'b1; end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/rsg_beam_ctr.sv
// Beam position counters: horizontal wraps after the line length, vertical
// steps on each horizontal wrap and wraps after the frame length.
// Assumes the totals may change at any time; a total below the current
// count lets the counter run through its natural width overflow.
module rsg_beam_ctr #(
    parameter int HW = 9,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] htotal,
    input  logic [VW-1:0] vtotal,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos
);
    logic line_end;
    logic frame_end;

    // Detect the last slot of a line and the last line of a frame.
    always_comb begin
        line_end  = (hpos == htotal);
        frame_end = (vpos == vtotal);
    end

    // Advance the horizontal and vertical counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hpos <= '0;
            vpos <= '0;
        end else if (line_end) begin
            hpos <= '0;
            vpos <= frame_end ? '0 : vpos + 1'b1;
        end else begin
            hpos <= hpos + 1'b1;
        end
    end
endmodule

// File: rtl/rsg_edge_flag.sv
// Set/clear level flag: clear wins over set, both gated by an enable.
// Exposes the next value so a combined output can share the same edge.
module rsg_edge_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_hit,
    input  logic clr_hit,
    output logic q,
    output logic q_next
);
    // Resolve the next level from the enabled hits.
    always_comb begin
        q_next = q;
        if (en && set_hit) q_next = 1'b1;
        if (en && clr_hit) q_next = 1'b0;
    end

    // Hold the level.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= 1'b0;
        else        q <= q_next;
    end
endmodule

// File: rtl/rsg_sync_core.sv
// Comparator bank and output flags. Horizontal flags compare the selected
// horizontal count; vertical sync is evaluated at the sync-start point on a
// short field and at the centre point on a long field. Blank compares use
// only the low CW bits of the blank registers. Assumes HW > CW.
module rsg_sync_core #(
    parameter int HW = 9,
    parameter int VW = 11,
    parameter int BW = 11,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] hcmp,
    input  logic [VW-1:0] vpos,
    input  logic          long_frame,
    input  logic          h_en,
    input  logic          v_en,
    input  logic [HW-1:0] hs_on,
    input  logic [HW-1:0] hs_off,
    input  logic [BW-1:0] hb_on,
    input  logic [BW-1:0] hb_off,
    input  logic [HW-1:0] hmid,
    input  logic [VW-1:0] vs_on,
    input  logic [VW-1:0] vs_off,
    input  logic [VW-1:0] vb_on,
    input  logic [VW-1:0] vb_off,
    output logic          hsync,
    output logic          hblank,
    output logic          vsync,
    output logic          vblank,
    output logic          csync
);
    localparam int NFLAG = 4;
    localparam int F_HS  = 0;
    localparam int F_HB  = 1;
    localparam int F_VS  = 2;
    localparam int F_VB  = 3;

    logic [NFLAG-1:0] en_v, set_v, clr_v, q_v, nxt_v;
    logic             vpoint;
    logic             unused_hb_hi;

    assign unused_hb_hi = ^{hb_on[BW-1:CW], hb_off[BW-1:CW]};

    // Build the per-flag enables and match hits.
    always_comb begin
        vpoint      = long_frame ? (hcmp == hmid) : (hcmp == hs_on);
        en_v[F_HS]  = h_en;
        set_v[F_HS] = (hcmp == hs_on);
        clr_v[F_HS] = (hcmp == hs_off);
        en_v[F_HB]  = h_en;
        set_v[F_HB] = (hcmp == HW'(hb_on[CW-1:0]));
        clr_v[F_HB] = (hcmp == HW'(hb_off[CW-1:0]));
        en_v[F_VS]  = v_en && vpoint;
        set_v[F_VS] = (vpos == vs_on);
        clr_v[F_VS] = (vpos == vs_off);
        en_v[F_VB]  = v_en;
        set_v[F_VB] = (vpos == vb_on);
        clr_v[F_VB] = (vpos == vb_off);
    end

    genvar gi;
    generate
        for (gi = 0; gi < NFLAG; gi++) begin : g_flag
            rsg_edge_flag u_flag (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en_v[gi]),
                .set_hit (set_v[gi]),
                .clr_hit (clr_v[gi]),
                .q       (q_v[gi]),
                .q_next  (nxt_v[gi])
            );
        end
    endgenerate

    // Register the composite sync on the same edge as the two syncs.
    always_ff @(posedge clk) begin
        if (!rst_n) csync <= 1'b0;
        else        csync <= nxt_v[F_HS] | nxt_v[F_VS];
    end

    assign hsync  = q_v[F_HS];
    assign hblank = q_v[F_HB];
    assign vsync  = q_v[F_VS];
    assign vblank = q_v[F_VB];
endmodule

// File: rtl/rsg_sync_gen.sv
// Top of the programmable raster sync generator: register file, beam
// counters and comparator bank. Assumes a single clock and synchronous
// active-low reset; hpos_alt is already in the clock domain.
module rsg_sync_gen #(
    parameter int HW        = 9,
    parameter int VW        = 11,
    parameter int BW        = 11,
    parameter int CW        = 8,
    parameter int AW        = 4,
    parameter int DW        = 16,
    parameter int HTOT_RST  = 227,
    parameter int HSON_RST  = 18,
    parameter int HSOFF_RST = 35,
    parameter int HBON_RST  = 9,
    parameter int HBOFF_RST = 44,
    parameter int HMID_RST  = 132,
    parameter int VTOT_RST  = 312,
    parameter int VSON_RST  = 2,
    parameter int VSOFF_RST = 5,
    parameter int VBON_RST  = 0,
    parameter int VBOFF_RST = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          dual_mode,
    input  logic [HW-1:0] hpos_alt,
    input  logic          long_frame,
    output logic [HW-1:0] hpos,
    output logic [VW-1:0] vpos,
    output logic          hsync,
    output logic          hblank,
    output logic          vsync,
    output logic          vblank,
    output logic          csync
);
    logic [HW-1:0] htotal, hs_on, hs_off, hmid, hcmp;
    logic [BW-1:0] hb_on, hb_off;
    logic [VW-1:0] vtotal, vs_on, vs_off, vb_on, vb_off;
    logic          h_en, v_en;

    rsg_regfile #(
        .HW(HW), .VW(VW), .BW(BW), .AW(AW), .DW(DW),
        .HTOT_RST(HTOT_RST), .HSON_RST(HSON_RST), .HSOFF_RST(HSOFF_RST),
        .HBON_RST(HBON_RST), .HBOFF_RST(HBOFF_RST), .HMID_RST(HMID_RST),
        .VTOT_RST(VTOT_RST), .VSON_RST(VSON_RST), .VSOFF_RST(VSOFF_RST),
        .VBON_RST(VBON_RST), .VBOFF_RST(VBOFF_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .htotal(htotal), .hs_on(hs_on), .hs_off(hs_off),
        .hb_on(hb_on), .hb_off(hb_off), .hmid(hmid), .vtotal(vtotal),
        .vs_on(vs_on), .vs_off(vs_off), .vb_on(vb_on), .vb_off(vb_off),
        .h_en(h_en), .v_en(v_en)
    );

    rsg_beam_ctr #(.HW(HW), .VW(VW)) u_beam (
        .clk(clk), .rst_n(rst_n), .htotal(htotal), .vtotal(vtotal),
        .hpos(hpos), .vpos(vpos)
    );

    // Pick the horizontal count the comparators look at.
    always_comb hcmp = dual_mode ? hpos_alt : hpos;

    rsg_sync_core #(.HW(HW), .VW(VW), .BW(BW), .CW(CW)) u_core (
        .clk(clk), .rst_n(rst_n), .hcmp(hcmp), .vpos(vpos),
        .long_frame(long_frame), .h_en(h_en), .v_en(v_en),
        .hs_on(hs_on), .hs_off(hs_off), .hb_on(hb_on), .hb_off(hb_off),
        .hmid(hmid), .vs_on(vs_on), .vs_off(vs_off), .vb_on(vb_on),
        .vb_off(vb_off), .hsync(hsync), .hblank(hblank), .vsync(vsync),
        .vblank(vblank), .csync(csync)
    );
endmodule

// File: rtl/rsg_sync_gen_chk.sv
// Cycle properties of the sync generator, bound into every instance.
module rsg_sync_gen_chk #(
    parameter int HW = 9,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] hpos,
    input logic [VW-1:0] vpos,
    input logic [HW-1:0] htotal,
    input logic [HW-1:0] hcmp,
    input logic [HW-1:0] hs_on,
    input logic          h_en,
    input logic          v_en,
    input logic          hsync,
    input logic          hblank,
    input logic          vsync,
    input logic          vblank,
    input logic          csync
);
    AST_HPOS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos == htotal) |=> (hpos == '0)); // R2
    AST_HPOS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != htotal) |=> (hpos == HW'($past(hpos) + 1'b1))); // R2
    AST_VPOS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (hpos != htotal) |=> $stable(vpos)); // R2
    AST_HSYNC_RISE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hsync) |-> ($past(hcmp) == $past(hs_on))); // R3
    AST_H_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !h_en |=> ($stable(hsync) && $stable(hblank))); // R9
    AST_V_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !v_en |=> ($stable(vsync) && $stable(vblank))); // R9
    AST_H_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        h_en |=> h_en); // R9
    AST_V_EN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        v_en |=> v_en); // R9
    AST_CSYNC_OR: assert property (@(posedge clk) disable iff (!rst_n)
        csync == (hsync | vsync)); // R13
endmodule

bind rsg_sync_gen rsg_sync_gen_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .htotal(htotal),
    .hcmp(hcmp), .hs_on(hs_on), .h_en(h_en), .v_en(v_en), .hsync(hsync),
    .hblank(hblank), .vsync(vsync), .vblank(vblank), .csync(csync)
);

// File: tb/rsg_sync_gen_test.sv
`timescale 1ns/1ps
module rsg_sync_gen_test;
    localparam int HW = 9;
    localparam int VW = 11;
    localparam int BW = 11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [15:0]   wr_data = '0;
    logic          dual_mode = 1'b0;
    logic [HW-1:0] hpos_alt = '0;
    logic          long_frame = 1'b0;
    logic [HW-1:0] hpos;
    logic [VW-1:0] vpos;
    logic          hsync, hblank, vsync, vblank, csync;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rsg_sync_gen uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .dual_mode(dual_mode), .hpos_alt(hpos_alt),
        .long_frame(long_frame), .hpos(hpos), .vpos(vpos), .hsync(hsync),
        .hblank(hblank), .vsync(vsync), .vblank(vblank), .csync(csync)
    );

    // Reference model state, built from the requirements.
    logic [HW-1:0] m_htot, m_hson, m_hsoff, m_hmid, m_hpos;
    logic [BW-1:0] m_hbon, m_hboff;
    logic [VW-1:0] m_vtot, m_vson, m_vsoff, m_vbon, m_vboff, m_vpos;
    logic          m_hen, m_ven, m_hs, m_hb, m_vs, m_vb, m_cs;

    task automatic check(string req, string name, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, name, act, exp);
        end
    endtask

    task automatic model_reset();
        m_htot = 227; m_hson = 18; m_hsoff = 35; m_hbon = 9; m_hboff = 44;
        m_hmid = 132; m_vtot = 312; m_vson = 2; m_vsoff = 5; m_vbon = 0;
        m_vboff = 20; m_hen = 0; m_ven = 0; m_hpos = 0; m_vpos = 0;
        m_hs = 0; m_hb = 0; m_vs = 0; m_vb = 0; m_cs = 0;
    endtask

    // Predict the state after the coming clock edge from current inputs.
    task automatic model_step();
        logic [HW-1:0] hc;
        logic          vpt, n_hs, n_hb, n_vs, n_vb;
        logic [HW-1:0] hv;
        logic [BW-1:0] bv;
        logic [VW-1:0] vv;
        if (!rst_n) begin
            model_reset();
            return;
        end
        hc   = dual_mode ? hpos_alt : m_hpos;
        n_hs = m_hs; n_hb = m_hb; n_vs = m_vs; n_vb = m_vb;
        if (m_hen) begin
            if (hc == m_hson) n_hs = 1;
            if (hc == m_hsoff) n_hs = 0;
            if (hc == HW'(m_hbon[7:0])) n_hb = 1;
            if (hc == HW'(m_hboff[7:0])) n_hb = 0;
        end
        vpt = long_frame ? (hc == m_hmid) : (hc == m_hson);
        if (m_ven && vpt) begin
            if (m_vpos == m_vson) n_vs = 1;
            if (m_vpos == m_vsoff) n_vs = 0;
        end
        if (m_ven) begin
            if (m_vpos == m_vbon) n_vb = 1;
            if (m_vpos == m_vboff) n_vb = 0;
        end
        if (m_hpos == m_htot) begin
            m_hpos = 0;
            m_vpos = (m_vpos == m_vtot) ? '0 : m_vpos + 1'b1;
        end else begin
            m_hpos = m_hpos + 1'b1;
        end
        m_hs = n_hs; m_hb = n_hb; m_vs = n_vs; m_vb = n_vb; m_cs = n_hs | n_vs;
        hv = wr_data[HW-1:0]; bv = wr_data[BW-1:0]; vv = wr_data[VW-1:0];
        if (wr_en) begin
            case (wr_addr)
                4'd0:  if (hv != m_htot)  begin m_htot = hv;  m_hen = 1; end
                4'd1:  if (hv != m_hson)  begin m_hson = hv;  m_hen = 1; end
                4'd2:  if (hv != m_hsoff) begin m_hsoff = hv; m_hen = 1; end
                4'd3:  if (bv != m_hbon)  begin m_hbon = bv;  m_hen = 1; end
                4'd4:  if (bv != m_hboff) begin m_hboff = bv; m_hen = 1; end
                4'd5:  if (hv != m_hmid)  begin m_hmid = hv;  m_hen = 1; end
                4'd6:  if (vv != m_vtot)  begin m_vtot = vv;  m_ven = 1; end
                4'd7:  if (vv != m_vson)  begin m_vson = vv;  m_ven = 1; end
                4'd8:  if (vv != m_vsoff) begin m_vsoff = vv; m_ven = 1; end
                4'd9:  if (vv != m_vbon)  begin m_vbon = vv;  m_ven = 1; end
                4'd10: if (vv != m_vboff) begin m_vboff = vv; m_ven = 1; end
                4'd11: if (wr_data[7:0] != 0) begin m_hen = 1; m_ven = 1; end
                default: ;
            endcase
        end
    endtask

    task automatic compare_all();
        check("R2", "hpos", int'(hpos), int'(m_hpos));
        check("R2", "vpos", int'(vpos), int'(m_vpos));
        check("R3 R8 R14", "hsync", int'(hsync), int'(m_hs));
        check("R4", "hblank", int'(hblank), int'(m_hb));
        check("R5 R6", "vsync", int'(vsync), int'(m_vs));
        check("R7", "vblank", int'(vblank), int'(m_vb));
        check("R13", "csync", int'(csync), int'(m_cs));
    endtask

    // One clock: drive at the falling edge, sample after the rising edge.
    task automatic tick(bit we, logic [3:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        model_step();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(1'b0, 4'd0, 16'd0);
    endtask

    task automatic rand_write();
        logic [3:0]  a;
        logic [15:0] d;
        a = 4'($urandom_range(0, 11));
        case (a)
            4'd0:             d = (16'($urandom) & 16'hFE00) | 16'($urandom_range(12, 24));
            4'd1, 4'd2, 4'd5: d = (16'($urandom) & 16'hFE00) | 16'($urandom_range(0, 25));
            4'd3, 4'd4:       d = (16'($urandom) & 16'hFF00) | 16'($urandom_range(0, 25));
            4'd6:             d = (16'($urandom) & 16'hF800) | 16'($urandom_range(4, 9));
            4'd11:            d = ($urandom_range(0, 1) == 1) ? 16'($urandom) : 16'h0100;
            default:          d = (16'($urandom) & 16'hF800) | 16'($urandom_range(0, 10));
        endcase
        tick(1'b1, a, d);
    endtask

    initial begin : watchdog
        #1000000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        bit seen;
        void'($urandom(32'd24681));
        model_reset();
        for (int i = 0; i < 5; i++) tick(1'b0, 4'd0, 16'd0);
        // R1: reset state
        check("R1", "reset hsync", int'(hsync), 0);
        check("R1", "reset vblank", int'(vblank), 0);
        check("R1", "reset hpos", int'(hpos), 0);
        rst_n = 1'b1;
        idle(3);
        check("R1", "post-reset hpos", int'(hpos), 3);

        // R11: unchanged write leaves comparisons off
        tick(1'b1, 4'd1, 16'd18);
        idle(240);
        check("R11", "hsync after unchanged write", int'(hsync), 0);
        check("R2", "vpos after one line", int'(vpos), 1);

        // R10: zero mode write is ignored, nonzero enables both
        tick(1'b1, 4'd11, 16'hFF00);
        idle(240);
        check("R10", "hsync after zero mode write", int'(hsync), 0);
        tick(1'b1, 4'd11, 16'h0040);
        seen = 0;
        for (int i = 0; i < 240; i++) begin
            tick(1'b0, 4'd0, 16'd0);
            if (hsync) seen = 1;
        end
        check("R10", "hsync seen after mode enable", int'(seen), 1);

        // Short line and frame for directed work
        tick(1'b1, 4'd0, 16'd15);
        tick(1'b1, 4'd6, 16'd6);
        idle(300);
        // R12: high bits dropped from the sync start value
        tick(1'b1, 4'd1, 16'hFE05);
        tick(1'b1, 4'd2, 16'd8);
        // R4: blank registers compare only their low byte
        tick(1'b1, 4'd3, 16'h0703);
        tick(1'b1, 4'd4, 16'h010A);
        idle(20);
        for (int i = 0; i < 32; i++) begin
            tick(1'b0, 4'd0, 16'd0);
            if (hpos == 9'd6)  check("R12", "hsync after masked start", int'(hsync), 1);
            if (hpos == 9'd9)  check("R3", "hsync after stop", int'(hsync), 0);
            if (hpos == 9'd4)  check("R4", "hblank after low-byte start", int'(hblank), 1);
            if (hpos == 9'd11) check("R4", "hblank after low-byte stop", int'(hblank), 0);
        end

        // R8: dual-counter mode uses the external count
        dual_mode = 1'b1;
        hpos_alt  = 9'd12;
        idle(4);
        hpos_alt = 9'd5;
        tick(1'b0, 4'd0, 16'd0);
        hpos_alt = 9'd12;
        idle(20);
        check("R8", "hsync held by external count", int'(hsync), 1);
        dual_mode = 1'b0;

        // R6: long field evaluates vertical sync at the centre point
        long_frame = 1'b1;
        tick(1'b1, 4'd5, 16'd13);
        idle(200);
        long_frame = 1'b0;

        // Random phase: writes, field and dual-mode changes
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 63) == 0) long_frame = ~long_frame;
            if ($urandom_range(0, 127) == 0) dual_mode = ~dual_mode;
            hpos_alt = 9'($urandom_range(0, 25));
            if ($urandom_range(0, 7) == 0) rand_write();
            else tick(1'b0, 4'd0, 16'd0);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule